// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block is the host-side engine that runs one register access or one PIO data word on a parallel ATA bus. A client presents a request: a four-bit address, a direction bit and, for writes, a data word. The sequencer then drives the chip selects and the three device address lines, waits a programmed setup count, and pulses the read or write strobe. The device's IORDY line passes through a two-stage synchronizer and is sampled at one fixed point after the strobe asserts. If it is low there, the strobe is stretched until IORDY returns high. Read data is captured as the strobe negates. The block then holds the address for a recovery count and reports completion with a one-cycle `done` pulse.

All timings are counts of system clocks. They are taken from the configuration inputs when a request is accepted: setup, sample point, minimum active width, recovery and wait limit. If IORDY never returns, the wait limit aborts the cycle. The strobe is released and `err` pulses in place of `done`. The DMA acknowledge output is held negated, because this engine only runs register and PIO transfers.

Top module: `ata_pio_ctrl`

## Requirements
- R1: After reset, both chip selects and both strobes are high, `ata_dd_oe`, `busy`, `done` and `err` are low, and `ata_dmack_n` is high.
- R2: Address bit 3 picks the chip select: 0 drives `ata_cs0_n` low, 1 drives `ata_cs1_n` low. Bits 2:0 appear on `ata_da`. All three hold from the first cycle after acceptance through the last recovery cycle.
- R3: The address is valid with both strobes high for max(cfg_setup,1) cycles before the strobe asserts. A write (`req_write`=1) pulses only `ata_wr_n` and a read pulses only `ata_rd_n`.
- R4: If the synchronized IORDY is high in the strobe cycle numbered cfg_sample (cycle 0 is the first strobe-low cycle), no wait is added. This also holds when IORDY was low earlier and has returned high by then. The strobe is then low for max(cfg_active, cfg_sample+1, 1) cycles.
- R5: If the synchronized IORDY is low at that point, the strobe stays low until IORDY is high again. It negates on the third rising clock edge after IORDY rises, but never before max(cfg_active,1) low cycles.
- R6: If IORDY stays low for max(cfg_limit,1) cycles after the wait starts, the strobe negates and `err` pulses for one cycle instead of `done`. `rdata` keeps its previous value.
- R7: After the strobe negates, the address stays driven for max(cfg_recover,1) cycles. It is then released, and `done` pulses for one cycle in the same cycle that `busy` falls.
- R8: On a read, `rdata` takes `ata_dd_in` at the edge where the strobe negates and is valid while `done` is high. After a wait, this is the value the device presents once IORDY has returned.
- R9: On a write, `ata_dd_oe` is high and `ata_dd_out` equals `req_wdata` for the whole busy period. On a read, `ata_dd_oe` stays low.
- R10: `ata_dmack_n` stays high at all times.
- R11: `req_valid` is ignored while busy. The configuration inputs are captured at acceptance, so changing them mid-cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Bit 3 chip-select pick, bits 2:0 device address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 8 | Address-to-strobe setup count |
| cfg_sample | input | 8 | Strobe cycle index where IORDY is judged |
| cfg_active | input | 8 | Minimum strobe-low count |
| cfg_recover | input | 8 | Address hold count after strobe negation |
| cfg_limit | input | 8 | Wait limit before abort |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle normal completion pulse |
| err | output | 1 | One-cycle wait-abort pulse |
| rdata | output | 16 | Captured read data |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dmack_n | output | 1 | DMA acknowledge, held high |
| ata_dd_out | output | 16 | Data bus drive value |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Data bus sampled value |
| ata_iordy | input | 1 | Device ready, asynchronous |

## Verification
Every pin result is registered, so it changes on the clock edge that ends the phase before it. Address and data-enable appear in the first cycle after the accepting edge. The strobe falls after exactly the setup count. Without a wait, it rises after max(active, sample+1) low cycles. With a wait, it rises three edges after IORDY rises, and `done` appears in the cycle after the last recovery cycle. The bench drives inputs and samples outputs on falling edges. It counts setup, strobe-low and recovery cycles one sample at a time against these formulas. It raises IORDY in a chosen strobe cycle, one cycle either side of the sample-point boundary, so the wait decision is tested exactly at its edge.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   // number of device address lines; the chip-select pick sits just above them
   localparam int PIO_DA_W = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLDOFF,
      PH_RECOVER
   } pio_phase_e;

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ata_pio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in};
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ata_pio_tick.sv
module ata_pio_tick #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] count
);

   if (W < 2) begin : g_bad_width
      $error("ata_pio_tick: W must be at least 2");
   end

   localparam logic [W-1:0] STEP = W'(1);

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   count <= '0;
         else if (clr)                 count <= '0;
         else if (en && (count != '1)) count <= count + STEP;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (clr) count <= '0;
         else if (en)  count <= count + STEP;
      end
   end

endmodule

// File: rtl/ata_pio_addr_hold.sv
module ata_pio_addr_hold
   import ata_pio_pkg::*;
#(
   parameter int DW   = 16,
   parameter int DA_W = PIO_DA_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            drop,
   input  logic [DA_W:0]   addr,
   input  logic            write,
   input  logic [DW-1:0]   wdata,
   output logic            cs0_n,
   output logic            cs1_n,
   output logic [DA_W-1:0] da,
   output logic [DW-1:0]   dd_out,
   output logic            dd_oe,
   output logic            dir_wr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs0_n  <= 1'b1;
         cs1_n  <= 1'b1;
         da     <= '0;
         dd_out <= '0;
         dd_oe  <= 1'b0;
         dir_wr <= 1'b0;
      end else if (load) begin
         cs0_n  <= addr[DA_W];
         cs1_n  <= ~addr[DA_W];
         da     <= addr[DA_W-1:0];
         dd_out <= wdata;
         dd_oe  <= write;
         dir_wr <= write;
      end else if (drop) begin
         cs0_n  <= 1'b1;
         cs1_n  <= 1'b1;
         dd_oe  <= 1'b0;
      end
   end

endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
   import ata_pio_pkg::*;
#(
   parameter int DW          = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [PIO_DA_W:0]   req_addr,
   input  logic [DW-1:0]       req_wdata,
   input  logic [CNT_W-1:0]    cfg_setup,
   input  logic [CNT_W-1:0]    cfg_sample,
   input  logic [CNT_W-1:0]    cfg_active,
   input  logic [CNT_W-1:0]    cfg_recover,
   input  logic [CNT_W-1:0]    cfg_limit,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [DW-1:0]       rdata,
   output logic                ata_cs0_n,
   output logic                ata_cs1_n,
   output logic [PIO_DA_W-1:0] ata_da,
   output logic                ata_rd_n,
   output logic                ata_wr_n,
   output logic                ata_dmack_n,
   output logic [DW-1:0]       ata_dd_out,
   output logic                ata_dd_oe,
   input  logic [DW-1:0]       ata_dd_in,
   input  logic                ata_iordy
);

   if (DW < 8) begin : g_bad_dw
      $error("ata_pio_ctrl: DW must be at least 8");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("ata_pio_ctrl: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   pio_phase_e        st, nxt;
   logic              rdy_s;
   logic [CNT_W-1:0]  ph_cnt, to_cnt;
   logic              ph_clr, to_clr;
   logic              timeout_hit;
   logic              abort_q;
   logic              dir_wr;
   logic              accept, release_a, capture, strobe_nxt;
   logic [CNT_W-1:0]  su_q, ta_q, act_q, rc_q, tmo_q, last_q;
   logic [CNT_W-1:0]  act_c;

   // Ready line into the clock domain
   ata_pio_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ata_iordy),
      .sync_out (rdy_s)
   );

   // Phase counter: runs through strobe and hold-off without restarting
   ata_pio_tick #(.W(CNT_W), .SATURATE(1'b1)) u_phase_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ph_clr),
      .en    (1'b1),
      .count (ph_cnt)
   );

   // Wait-limit counter: runs only in hold-off
   ata_pio_tick #(.W(CNT_W), .SATURATE(1'b1)) u_limit_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (to_clr),
      .en    (1'b1),
      .count (to_cnt)
   );

   assign accept    = (st == PH_IDLE) && req_valid;
   assign release_a = (st == PH_RECOVER) && (nxt == PH_IDLE);

   ata_pio_addr_hold #(.DW(DW), .DA_W(PIO_DA_W)) u_addr_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .drop   (release_a),
      .addr   (req_addr),
      .write  (req_write),
      .wdata  (req_wdata),
      .cs0_n  (ata_cs0_n),
      .cs1_n  (ata_cs1_n),
      .da     (ata_da),
      .dd_out (ata_dd_out),
      .dd_oe  (ata_dd_oe),
      .dir_wr (dir_wr)
   );

   always_comb begin
      nxt         = st;
      timeout_hit = 1'b0;
      unique case (st)
         PH_IDLE:    if (req_valid) nxt = PH_SETUP;
         PH_SETUP:   if (ph_cnt == su_q - CNT_ONE) nxt = PH_STROBE;
         PH_STROBE: begin
            if ((ph_cnt == ta_q) && !rdy_s) nxt = PH_HOLDOFF;
            else if (ph_cnt == last_q)      nxt = PH_RECOVER;
         end
         PH_HOLDOFF: begin
            if (rdy_s) begin
               if (ph_cnt >= act_q - CNT_ONE) nxt = PH_RECOVER;
            end else if (to_cnt == tmo_q - CNT_ONE) begin
               nxt         = PH_RECOVER;
               timeout_hit = 1'b1;
            end
         end
         PH_RECOVER: if (ph_cnt == rc_q - CNT_ONE) nxt = PH_IDLE;
         default:    nxt = PH_IDLE;
      endcase
   end

   assign ph_clr     = (st == PH_IDLE) || ((nxt != st) && (nxt != PH_HOLDOFF));
   assign to_clr     = (st != PH_HOLDOFF);
   assign strobe_nxt = (nxt == PH_STROBE) || (nxt == PH_HOLDOFF);
   assign capture    = ((st == PH_STROBE) || (st == PH_HOLDOFF)) && (nxt == PH_RECOVER)
                       && !timeout_hit && !dir_wr;
   assign act_c      = (cfg_active == '0) ? CNT_ONE : cfg_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PH_IDLE;
         busy     <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         abort_q  <= 1'b0;
         rdata    <= '0;
         ata_rd_n <= 1'b1;
         ata_wr_n <= 1'b1;
         su_q     <= CNT_ONE;
         ta_q     <= '0;
         act_q    <= CNT_ONE;
         rc_q     <= CNT_ONE;
         tmo_q    <= CNT_ONE;
         last_q   <= '0;
      end else begin
         st       <= nxt;
         busy     <= (nxt != PH_IDLE);
         done     <= release_a && !abort_q;
         err      <= release_a && abort_q;
         ata_rd_n <= ~(strobe_nxt && !dir_wr);
         ata_wr_n <= ~(strobe_nxt && dir_wr);
         if (capture) rdata <= ata_dd_in;
         if (accept) begin
            abort_q <= 1'b0;
            su_q    <= (cfg_setup   == '0) ? CNT_ONE : cfg_setup;
            rc_q    <= (cfg_recover == '0) ? CNT_ONE : cfg_recover;
            tmo_q   <= (cfg_limit   == '0) ? CNT_ONE : cfg_limit;
            act_q   <= act_c;
            ta_q    <= cfg_sample;
            last_q  <= ((act_c - CNT_ONE) > cfg_sample) ? (act_c - CNT_ONE) : cfg_sample;
         end else if (timeout_hit) begin
            abort_q <= 1'b1;
         end
      end
   end

   assign ata_dmack_n = 1'b1;

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_rd_n && !ata_wr_n));

   // R2
   strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_rd_n || !ata_wr_n) |-> (ata_cs0_n != ata_cs1_n));

   // R2
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ata_da) && $stable(ata_cs0_n) && $stable(ata_cs1_n)));

   // R6
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R7
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> (ata_cs0_n && ata_cs1_n && !busy));

   // R7
   recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ata_rd_n) || $rose(ata_wr_n)) |-> (busy && !(ata_cs0_n && ata_cs1_n)));

   // R9
   oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ata_dd_oe |-> busy);

endmodule

// File: tb/ata_pio_ctrl_bench.sv
module ata_pio_ctrl_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [7:0]  cfg_setup = 8'd1, cfg_sample = 8'd1, cfg_active = 8'd1;
   logic [7:0]  cfg_recover = 8'd1, cfg_limit = 8'd8;
   logic        busy, done, err;
   logic [15:0] rdata;
   logic        ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_dmack_n, ata_dd_oe;
   logic [2:0]  ata_da;
   logic [15:0] ata_dd_out;
   logic [15:0] ata_dd_in = 16'h0000;
   logic        ata_iordy = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   int dmack_bad = 0;
   int m_su, m_low, m_rc;
   int m_done, m_err;
   logic [15:0] m_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   ata_pio_ctrl u_ata_pio_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_setup(cfg_setup), .cfg_sample(cfg_sample), .cfg_active(cfg_active),
      .cfg_recover(cfg_recover), .cfg_limit(cfg_limit),
      .busy(busy), .done(done), .err(err), .rdata(rdata),
      .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
      .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dmack_n(ata_dmack_n),
      .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
      .ata_iordy(ata_iordy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // raise_at: -1 = IORDY high throughout, -2 = never high, k = raise in strobe cycle k
   task automatic xfer(input logic [3:0] a, input bit w, input logic [15:0] wd,
                       input logic [15:0] rv, input int raise_at, input bit disturb,
                       input int su, input int ta, input int act, input int rc, input int tmo);
      cfg_setup   = su[7:0];
      cfg_sample  = ta[7:0];
      cfg_active  = act[7:0];
      cfg_recover = rc[7:0];
      cfg_limit   = tmo[7:0];
      if (raise_at == -1) begin ata_iordy = 1'b1; ata_dd_in = rv; end
      else begin ata_iordy = 1'b0; ata_dd_in = 16'hDEAD; end
      m_su = 0; m_low = 0; m_rc = 0; m_done = 0; m_err = 0; m_rdata = '0;
      @(negedge clk);
      @(negedge clk);
      req_addr = a; req_write = w; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int guard = 0; guard < 600; guard++) begin
         if (!ata_dmack_n) dmack_bad++;
         if (done || err) begin
            m_done = int'(done); m_err = int'(err); m_rdata = rdata;
            chk("R7 chip selects released at completion", int'(ata_cs0_n && ata_cs1_n), 1);
            chk("R7 busy low at completion", int'(busy), 0);
            break;
         end
         chk("R2 cs0_n", int'(ata_cs0_n), int'(a[3]));
         chk("R2 cs1_n", int'(ata_cs1_n), int'(!a[3]));
         chk("R2 da", int'(ata_da), int'(a[2:0]));
         chk("R9 dd_oe", int'(ata_dd_oe), int'(w));
         if (w) chk("R9 dd_out", int'(ata_dd_out), int'(wd));
         if (!ata_rd_n || !ata_wr_n) begin
            chk("R3 write strobe select", int'(ata_wr_n), int'(!w));
            chk("R3 read strobe select", int'(ata_rd_n), int'(w));
            if (raise_at == m_low) begin ata_iordy = 1'b1; ata_dd_in = rv; end
            if (disturb && m_low == 0) begin
               req_valid = 1'b1; req_addr = 4'h0; cfg_active = 8'd1;
            end else if (disturb && m_low == 1) begin
               req_valid = 1'b0;
            end
            m_low++;
         end else if (m_low == 0) begin
            m_su++;
         end else begin
            m_rc++;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk("R7 completion pulse lasts one cycle", int'(done || err), 0);
      ata_iordy = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 cs0_n", int'(ata_cs0_n), 1);
      chk("R1 cs1_n", int'(ata_cs1_n), 1);
      chk("R1 rd_n", int'(ata_rd_n), 1);
      chk("R1 wr_n", int'(ata_wr_n), 1);
      chk("R1 dd_oe", int'(ata_dd_oe), 0);
      chk("R1 busy/done/err", int'({busy, done, err}), 0);
      chk("R1 dmack_n", int'(ata_dmack_n), 1);
   endtask

   task automatic t_read_plain();
      xfer(4'h5, 1'b0, 16'h0, 16'h1234, -1, 1'b0, 2, 4, 3, 2, 20);
      chk("R3 setup cycles", m_su, 2);
      chk("R4 strobe low cycles", m_low, 5);
      chk("R7 recovery cycles", m_rc, 2);
      chk("R7 done", m_done, 1);
      chk("R8 read data", int'(m_rdata), 16'h1234);
   endtask

   task automatic t_write_plain();
      xfer(4'hE, 1'b1, 16'hA5C3, 16'h0, -1, 1'b0, 1, 1, 6, 3, 20);
      chk("R3 setup cycles write", m_su, 1);
      chk("R4 strobe low cycles write", m_low, 6);
      chk("R7 recovery cycles write", m_rc, 3);
      chk("R7 done write", m_done, 1);
      chk("R9 dd_oe low after write", int'(ata_dd_oe), 0);
   endtask

   task automatic t_ready_returned();
      xfer(4'h2, 1'b0, 16'h0, 16'h5A5A, 2, 1'b0, 1, 4, 3, 1, 20);
      chk("R4 returned-high no wait", m_low, 5);
      chk("R8 read data returned-high", int'(m_rdata), 16'h5A5A);
   endtask

   task automatic t_late_ready();
      xfer(4'h1, 1'b0, 16'h0, 16'hC001, 3, 1'b0, 1, 4, 3, 1, 20);
      chk("R5 wait inserted at boundary", m_low, 6);
      chk("R8 read data boundary wait", int'(m_rdata), 16'hC001);
   endtask

   task automatic t_long_wait();
      xfer(4'hC, 1'b0, 16'h0, 16'h7E81, 12, 1'b0, 2, 4, 3, 2, 40);
      chk("R5 long wait strobe low", m_low, 15);
      chk("R5 long wait done", m_done, 1);
      chk("R8 read data after wait", int'(m_rdata), 16'h7E81);
   endtask

   task automatic t_wait_below_active();
      xfer(4'h4, 1'b0, 16'h0, 16'h0F0F, 1, 1'b0, 1, 2, 12, 1, 40);
      chk("R5 wait keeps active width", m_low, 12);
      chk("R8 read data wide strobe", int'(m_rdata), 16'h0F0F);
   endtask

   task automatic t_timeout();
      xfer(4'h6, 1'b0, 16'h0, 16'hBEEF, -2, 1'b0, 1, 4, 3, 2, 10);
      chk("R6 timeout strobe low", m_low, 15);
      chk("R6 err pulse", m_err, 1);
      chk("R6 no done", m_done, 0);
      chk("R6 rdata unchanged", int'(m_rdata), 16'h0F0F);
   endtask

   task automatic t_zero_cfg();
      xfer(4'h9, 1'b0, 16'h0, 16'h3C3C, -1, 1'b0, 0, 0, 0, 0, 0);
      chk("R3 zero setup acts as one", m_su, 1);
      chk("R4 zero active acts as one", m_low, 1);
      chk("R7 zero recovery acts as one", m_rc, 1);
      chk("R8 zero cfg read data", int'(m_rdata), 16'h3C3C);
   endtask

   task automatic t_busy_ignore();
      xfer(4'h3, 1'b0, 16'h0, 16'h4242, -1, 1'b1, 2, 2, 8, 2, 20);
      chk("R11 cfg change mid-cycle ignored", m_low, 8);
      chk("R11 done once", m_done, 1);
      repeat (4) @(negedge clk);
      chk("R11 request while busy not started", int'(busy), 0);
      chk("R11 chip selects idle", int'(ata_cs0_n && ata_cs1_n), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_plain();
      t_write_plain();
      t_ready_returned();
      t_late_ready();
      t_long_wait();
      t_wait_below_active();
      t_timeout();
      t_zero_cfg();
      t_busy_ignore();
      chk("R10 dmack_n never low", dmack_bad, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      summary();
      $finish;
   end

endmodule